// File: doc/BRIEF.md
# Layered Scaled Min-Sum Check-Node Processor

This block is one soft-in soft-out check-node unit for a layered LDPC decoder. For one parity-check row at a time it receives, one bit per cycle, the current posterior LLR of each connected bit and the check-to-bit message that the same row left behind in the previous iteration. It subtracts the old message to form the bit-to-check message. It runs a scaled min-sum update over the row and returns, per bit, the new check-to-bit message and the refreshed posterior LLR. The next layer of the same iteration can use that posterior straight away.

Processing is serial and takes two passes. In the first pass the unit collects the row. It keeps the smallest and second-smallest magnitudes, the position of the smallest, the running sign parity and the parity of the input hard decisions, and it buffers every bit-to-check value in a small FIFO. In the second pass it replays the FIFO and emits one result per cycle in input order. While that pass runs, the unit refuses new input. The permutation network and the LLR and message memories sit outside this block.

Top module: `layered_minsum_cnu`

## Requirements
- R1: Each input beat carries an 8-bit two's-complement posterior LLR and a 6-bit two's-complement old check message. The bit-to-check value is their difference, saturated to [-128, 127].
- R2: The new message magnitude for a bit is the minimum, over all other bits of the row, of the bit-to-check magnitude clipped to 31. Ties between equal smallest magnitudes give every bit that same value.
- R3: The new message sign is negative exactly when an odd number of the other bits have a negative bit-to-check value. A zero value counts as non-negative.
- R4: The magnitude is scaled by 0.75 as floor(3m/4), which rounds toward zero. Every emitted check message therefore lies within [-23, 23].
- R5: The output posterior is the bit-to-check value plus the new check message, saturated to [-128, 127].
- R6: On every output beat of a row, the parity-failed flag equals the XOR of the input hard decisions of that row. The hard decision is 1 when the input posterior is negative and 0 otherwise.
- R7: A row of d beats, marked by a first flag on beat 0 and a last flag on beat d-1, yields exactly d output beats. These beats come in input order on consecutive cycles, with the last flag only on the final one.
- R8: Input ready is low from the cycle after the last input beat is accepted until the final output beat of that row is registered. A beat offered while ready is low is ignored.
- R9: Rows of degree 1 up to MAX_DEG are supported. A degree-1 row has no other bits, so it gets magnitude 31 scaled to 23, with a positive sign.
- R10: While reset is asserted and right after it is released, output valid is low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat valid |
| in_first_i | input | 1 | Beat is the first of a row |
| in_last_i | input | 1 | Beat is the last of a row |
| in_post_i | input | 8 | Posterior LLR of the bit, two's complement |
| in_oldc_i | input | 6 | Previous-iteration check message for the bit |
| in_ready_o | output | 1 | Unit accepts an input beat |
| out_valid_o | output | 1 | Output beat valid |
| out_last_o | output | 1 | Output beat is the last of the row |
| out_post_o | output | 8 | Updated posterior LLR |
| out_newc_o | output | 6 | New check-to-bit message |
| out_par_fail_o | output | 1 | Row parity of input hard decisions |

## Verification
The assertions check, on every cycle, the properties that can be seen without arithmetic on the data:
- the output beats of a row run back to back;
- the emitted message stays inside the scaled bound;
- the parity flag holds steady across a row;
- ready stays low while a row drains;
- the FIFO never overflows or underflows;
- a row never exceeds the supported degree.

Only the bench's scenarios can show that the values themselves are right. These scenarios cover correct minimum and second-minimum selection, sign products that treat zero as positive, saturation at both rails, ties, degree-1 and full-degree rows, and beats offered during emission being dropped.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  localparam int LLR_W = 8;
  localparam int MSG_W = 6;
  localparam int MAG_W = MSG_W - 1;
  localparam int MAG_MAX_INT = (1 << MAG_W) - 1;
  localparam int SCALED_MAX = (MAG_MAX_INT * 3) / 4;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic signed [MSG_W-1:0] msg_t;
  typedef logic        [MAG_W-1:0] mag_t;
  typedef logic signed [LLR_W+1:0] wide_t;

  localparam mag_t MAG_MAX = '1;

  function automatic wide_t ext_llr(input llr_t v);
    return {{2{v[LLR_W-1]}}, v};
  endfunction

  function automatic wide_t ext_msg(input msg_t v);
    return {{(LLR_W+2-MSG_W){v[MSG_W-1]}}, v};
  endfunction

  // clamp to the LLR range when the top three bits disagree
  function automatic llr_t sat_llr(input wide_t x);
    logic [2:0] top;
    top = x[LLR_W+1:LLR_W-1];
    if ((&top) || !(|top)) return x[LLR_W-1:0];
    return x[LLR_W+1] ? {1'b1, {(LLR_W-1){1'b0}}} : {1'b0, {(LLR_W-1){1'b1}}};
  endfunction

  function automatic mag_t mag_of(input llr_t q);
    logic [LLR_W:0] e;
    logic [LLR_W:0] a;
    e = {q[LLR_W-1], q};
    a = e[LLR_W] ? (~e + {{LLR_W{1'b0}}, 1'b1}) : e;
    if (a > {{(LLR_W+1-MAG_W){1'b0}}, MAG_MAX}) return MAG_MAX;
    return a[MAG_W-1:0];
  endfunction

  // floor(3m/4): 0.75 scaling, rounded toward zero on the magnitude
  function automatic mag_t scale_mag(input mag_t m);
    logic [MAG_W+1:0] t;
    t = {2'b00, m} + {1'b0, m, 1'b0};
    return t[MAG_W+1:2];
  endfunction

  function automatic msg_t to_msg(input logic neg, input mag_t m);
    msg_t t;
    t = {1'b0, m};
    return neg ? (msg_t'(0) - t) : t;
  endfunction
endpackage

// File: rtl/cnu_fifo.sv
module cnu_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0]   mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [PTR_W:0]   cnt_q;

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
      if (rd_i) rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9: a row never exceeds the buffer
  p_fifo_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (cnt_q < (PTR_W+1)'(DEPTH)));
  // R7: replay only reads stored values
  p_fifo_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (cnt_q != '0));
endmodule

// File: rtl/cnu_collect.sv
module cnu_collect import cnu_pkg::*; #(
  parameter int MAX_DEG = 8,
  localparam int IDX_W = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             first_i,
  input  logic             last_i,
  input  llr_t             post_i,
  input  msg_t             oldc_i,
  output llr_t             q_o,
  output logic             done_o,
  output mag_t             min1_o,
  output mag_t             min2_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sgn_o,
  output logic             par_o,
  output logic [IDX_W:0]   deg_o
);
  logic [IDX_W-1:0] cnt_q, idx_q, pos, b_idx;
  mag_t             min1_q, min2_q, b_min1, b_min2, m;
  logic             sgn_q, par_q, b_sgn, b_par;

  always_comb begin
    q_o = sat_llr(ext_llr(post_i) - ext_msg(oldc_i));
    m   = mag_of(q_o);
    if (first_i) begin
      b_min1 = MAG_MAX;
      b_min2 = MAG_MAX;
      b_idx  = '0;
      b_sgn  = 1'b0;
      b_par  = 1'b0;
      pos    = '0;
    end else begin
      b_min1 = min1_q;
      b_min2 = min2_q;
      b_idx  = idx_q;
      b_sgn  = sgn_q;
      b_par  = par_q;
      pos    = cnt_q + 1'b1;
    end
    min1_o = b_min1;
    min2_o = b_min2;
    idx_o  = b_idx;
    if (m < b_min1) begin
      min2_o = b_min1;
      min1_o = m;
      idx_o  = pos;
    end else if (m < b_min2) begin
      min2_o = m;
    end
    sgn_o  = b_sgn ^ q_o[LLR_W-1];
    par_o  = b_par ^ post_i[LLR_W-1];
    deg_o  = {1'b0, pos} + 1'b1;
    done_o = acc_i & last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      min1_q <= MAG_MAX;
      min2_q <= MAG_MAX;
      sgn_q  <= 1'b0;
      par_q  <= 1'b0;
    end else if (acc_i) begin
      cnt_q  <= pos;
      idx_q  <= idx_o;
      min1_q <= min1_o;
      min2_q <= min2_o;
      sgn_q  <= sgn_o;
      par_q  <= par_o;
    end
  end

  // R9: continuation beats stay within the supported degree
  p_degree_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !first_i) |-> (cnt_q < IDX_W'(MAX_DEG - 1)));
  // R2: the second minimum never undercuts the minimum
  p_min_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (min1_q <= min2_q));
endmodule

// File: rtl/cnu_emit.sv
module cnu_emit import cnu_pkg::*; #(
  parameter int MAX_DEG = 8,
  localparam int IDX_W = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mag_t             min1_i,
  input  mag_t             min2_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sgn_i,
  input  logic             par_i,
  input  logic [IDX_W:0]   deg_i,
  input  llr_t             q_i,
  output logic             rd_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic             last_o,
  output llr_t             post_o,
  output msg_t             newc_o,
  output logic             par_o
);
  logic             busy_q, sgn_q, par_q;
  logic [IDX_W:0]   rem_q;
  logic [IDX_W-1:0] pos_q, idx_q;
  mag_t             min1_q, min2_q, sel, scaled;
  msg_t             c_new;
  llr_t             p_new;

  always_comb begin
    sel    = (pos_q == idx_q) ? min2_q : min1_q;
    scaled = scale_mag(sel);
    c_new  = to_msg(sgn_q ^ q_i[LLR_W-1], scaled);
    p_new  = sat_llr(ext_llr(q_i) + ext_msg(c_new));
  end

  assign rd_o   = busy_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rem_q   <= '0;
      pos_q   <= '0;
      idx_q   <= '0;
      min1_q  <= '0;
      min2_q  <= '0;
      sgn_q   <= 1'b0;
      par_q   <= 1'b0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      post_o  <= '0;
      newc_o  <= '0;
      par_o   <= 1'b0;
    end else begin
      valid_o <= busy_q;
      last_o  <= busy_q && (rem_q == (IDX_W+1)'(1));
      if (busy_q) begin
        post_o <= p_new;
        newc_o <= c_new;
        par_o  <= par_q;
      end
      if (start_i) begin
        busy_q <= 1'b1;
        rem_q  <= deg_i;
        pos_q  <= '0;
        idx_q  <= idx_i;
        min1_q <= min1_i;
        min2_q <= min2_i;
        sgn_q  <= sgn_i;
        par_q  <= par_i;
      end else if (busy_q) begin
        rem_q <= rem_q - 1'b1;
        pos_q <= pos_q + 1'b1;
        if (rem_q == (IDX_W+1)'(1)) busy_q <= 1'b0;
      end
    end
  end

  // R7: beats of one row run back to back
  p_consecutive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);
  // R4: emitted messages respect the scaled bound
  p_newc_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((newc_o <= msg_t'(SCALED_MAX)) && (newc_o >= msg_t'(-SCALED_MAX))));
  // R6: the parity flag is constant across a row
  p_par_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> $stable(par_o));
  // R8: a new row never starts while one is draining
  p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/layered_minsum_cnu.sv
module layered_minsum_cnu import cnu_pkg::*; #(
  parameter int MAX_DEG = 8,
  localparam int IDX_W = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_first_i,
  input  logic             in_last_i,
  input  logic [LLR_W-1:0] in_post_i,
  input  logic [MSG_W-1:0] in_oldc_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic [LLR_W-1:0] out_post_o,
  output logic [MSG_W-1:0] out_newc_o,
  output logic             out_par_fail_o
);
  logic             acc, done, sgn, par, rd, busy;
  llr_t             q_wr, q_rd, post_s;
  msg_t             newc_s;
  mag_t             min1, min2;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   deg;

  assign in_ready_o = ~busy;
  assign acc        = in_valid_i & ~busy;

  cnu_collect #(.MAX_DEG(MAX_DEG)) u_collect (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc),
    .first_i(in_first_i), .last_i(in_last_i),
    .post_i(llr_t'(in_post_i)), .oldc_i(msg_t'(in_oldc_i)),
    .q_o(q_wr), .done_o(done), .min1_o(min1), .min2_o(min2),
    .idx_o(idx), .sgn_o(sgn), .par_o(par), .deg_o(deg)
  );

  cnu_fifo #(.DEPTH(MAX_DEG), .W(LLR_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(acc), .wdata_i(q_wr), .rd_i(rd), .rdata_o(q_rd)
  );

  cnu_emit #(.MAX_DEG(MAX_DEG)) u_emit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(done),
    .min1_i(min1), .min2_i(min2), .idx_i(idx), .sgn_i(sgn),
    .par_i(par), .deg_i(deg), .q_i(q_rd),
    .rd_o(rd), .busy_o(busy), .valid_o(out_valid_o), .last_o(out_last_o),
    .post_o(post_s), .newc_o(newc_s), .par_o(out_par_fail_o)
  );

  assign out_post_o = post_s;
  assign out_newc_o = newc_s;

  // R8: input is refused while a row is still being emitted
  p_ready_low_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> !in_ready_o);
  // R10: reset leaves no output pending
  p_reset_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o);
endmodule

// File: tb/layered_minsum_cnu_bench.sv
module layered_minsum_cnu_bench;
  localparam int MAXD = 8;
  localparam int NT = 5;
  localparam int T_DEG [NT] = '{4, 6, 3, 5, 2};
  localparam int T_POST [NT][6] = '{
    '{  20, -15,   7,  40,   0,  0},
    '{ 127,-128,   5,  -5,   0, 60},
    '{  -9,   9,  -9,   0,   0,  0},
    '{ 100,-100,  50, -50,   3,  0},
    '{  -1,   2,   0,   0,   0,  0}};
  localparam int T_OLDC [NT][6] = '{
    '{   3,  -2,   0,  10,   0,  0},
    '{ -20,  31,   5,  -5,   0, -1},
    '{   0,   0,   0,   0,   0,  0},
    '{ -10,  10,  -5,   5,   2,  0},
    '{   0,   0,   0,   0,   0,  0}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_post = '0;
  logic [5:0] in_oldc = '0;
  logic       in_ready, out_valid, out_last, out_par;
  logic [7:0] out_post;
  logic [5:0] out_newc;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  layered_minsum_cnu #(.MAX_DEG(MAXD)) u_layered_minsum_cnu (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_first_i(in_first),
    .in_last_i(in_last), .in_post_i(in_post), .in_oldc_i(in_oldc),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_last_o(out_last),
    .out_post_o(out_post), .out_newc_o(out_newc), .out_par_fail_o(out_par)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int sat8(input int x);
    return (x > 127) ? 127 : ((x < -128) ? -128 : x);
  endfunction

  function automatic int mag31(input int q);
    int a;
    a = (q < 0) ? -q : q;
    return (a > 31) ? 31 : a;
  endfunction

  task automatic model(input int deg, input int p[MAXD], input int c[MAXD],
                       output int ep[MAXD], output int ec[MAXD], output int par);
    int q[MAXD];
    par = 0;
    for (int i = 0; i < MAXD; i++) begin
      q[i] = 0; ep[i] = 0; ec[i] = 0;
    end
    for (int i = 0; i < deg; i++) begin
      q[i] = sat8(p[i] - c[i]);
      if (p[i] < 0) par ^= 1;
    end
    for (int i = 0; i < deg; i++) begin
      int m;
      int neg;
      int s;
      m = 31;
      neg = 0;
      for (int j = 0; j < deg; j++) begin
        if (j != i) begin
          if (mag31(q[j]) < m) m = mag31(q[j]);
          if (q[j] < 0) neg ^= 1;
        end
      end
      s = (3 * m) / 4;
      ec[i] = neg ? -s : s;
      ep[i] = sat8(q[i] + ec[i]);
    end
  endtask

  task automatic run_row(input int deg, input int p[MAXD], input int c[MAXD], input bit spam);
    int ep[MAXD];
    int ec[MAXD];
    int par;
    int t;
    model(deg, p, c, ep, ec, par);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int b = 0; b < deg; b++) begin
      in_valid = 1'b1;
      in_first = (b == 0);
      in_last  = (b == deg - 1);
      in_post  = 8'(p[b]);
      in_oldc  = 6'(c[b]);
      @(negedge clk);
    end
    if (spam) begin
      // offered while the row drains: must be dropped (R8)
      check(in_ready == 1'b0, "R8 ready during drain", int'(in_ready), 0);
      in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1;
      in_post = 8'd77; in_oldc = 6'd9;
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    t = 0;
    while (!out_valid && t < 20) begin
      @(negedge clk);
      t++;
    end
    for (int i = 0; i < deg; i++) begin
      check(out_valid == 1'b1, "R7 consecutive valid", int'(out_valid), 1);
      check($signed(out_post) == ep[i], "R1/R5 posterior", int'($signed(out_post)), ep[i]);
      check($signed(out_newc) == ec[i], "R2/R3/R4 check message", int'($signed(out_newc)), ec[i]);
      check(out_last == (i == deg - 1), "R7 last flag", int'(out_last), int'(i == deg - 1));
      if (i == deg - 1) check(out_par == par[0], "R6 parity flag", int'(out_par), par);
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      check(out_valid == 1'b0, "R7/R8 no extra beats", int'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int p[MAXD];
    int c[MAXD];
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);

    for (int r = 0; r < NT; r++) begin
      for (int i = 0; i < MAXD; i++) begin
        p[i] = (i < 6) ? T_POST[r][i] : 0;
        c[i] = (i < 6) ? T_OLDC[r][i] : 0;
      end
      run_row(T_DEG[r], p, c, 1'b0);
    end

    // R9: degree-1 row
    for (int i = 0; i < MAXD; i++) begin p[i] = 0; c[i] = 0; end
    p[0] = -40; c[0] = -3;
    run_row(1, p, c, 1'b0);

    // R9/R8: full-degree row with a beat offered during drain
    p = '{ -70, 12, 31, -31, 0, 127, -128, 6 };
    c = '{  10, -1,  0,  -8, 0, -32,   31, 6 };
    run_row(MAXD, p, c, 1'b1);

    // R3: all-zero row, zero counts as non-negative
    for (int i = 0; i < MAXD; i++) begin p[i] = 0; c[i] = 0; end
    run_row(3, p, c, 1'b1);

    // R2: large equal magnitudes clip to 31
    p = '{ -90, 90, -100, 64, 0, 0, 0, 0 };
    c = '{   0,  0,    0,  0, 0, 0, 0, 0 };
    run_row(4, p, c, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule